// File: doc/BRIEF.md
# Width-Switchable Processor Register File

This block holds the programmer-visible registers of an 8/16-bit processor core: an accumulator split into a low half A and a high half B, two index registers X and Y, a 16-bit stack pointer, a 16-bit direct-page base and an 8-bit status register. Two status bits and an emulation flag control the width that the accumulator and the index registers present to the datapath. Clearing the accumulator-width bit joins A and B into one 16-bit accumulator. Clearing the index-width bit widens X and Y to 16 bits. The two bits are independent of each other.

The core's decoder drives one operation per cycle. `op_valid` qualifies a 4-bit `op_sel` code, and `wr_data` carries load data or a flag mask. Each operation is a load, a register-to-register transfer, a half swap, a carry/emulation exchange, or a status clear/set. The results are registered and appear on the outputs one clock after the operation is accepted. Zero and negative flags are updated at the width of the destination.

The mode controller is a two-state machine. MODE_EMU is entered on reset. The transition EMU_TO_NATIVE fires on an exchange while carry is 0. The transition NATIVE_TO_EMU fires on an exchange while carry is 1. Any other exchange keeps the current state. In MODE_EMU both width bits read 1 and the stack pointer high byte is pinned to 0x01.

Top module: `cpu_regfile`

## Requirements
- R1: When `rst_n` is low, the outputs return to: emulation flag 1, status 0x34, stack pointer 0x01FF, and A, B, X, Y and direct page all 0.
- R2: Load-accumulator (code 1) and index-to-accumulator (codes 6, 7) writes go to A only when status bit 5 (m) is 1, and B keeps its value. When m is 0 these writes cover both halves. `acc_out` shows {0x00, A} when m is 1 and {B, A} when m is 0.
- R3: While status bit 4 (x) is 1, the high bytes of X and Y are 0. Loads (codes 2, 3) and transfers from the accumulator (codes 4, 5) write only the low byte. Setting x clears both high bytes, and they stay 0 after x is later cleared.
- R4: The m and x bits can be changed independently in native mode. Each keeps its own value when the other one changes.
- R5: The accumulator-to-direct-page, direct-page-to-accumulator, accumulator-to-stack and stack-to-accumulator transfers (codes 8, 9, 10, 11) always move 16 bits, whatever m is. Code 10 leaves the flags unchanged.
- R6: The exchange (code 13) sets the emulation flag to the old carry (status bit 0) and sets the carry to the old emulation flag. Clearing carry and then exchanging moves the block from emulation to native mode.
- R7: In emulation mode, m and x read 1 and cannot be cleared, and the stack pointer high byte is 0x01. The stack transfer (code 10) loads only the low byte. Entering emulation forces m and x to 1, clears the index high bytes and sets the stack high byte to 0x01.
- R8: Loads and transfers (codes 1–7, 9, 11, 12) set N (bit 7) and Z (bit 1) from bit 7 and the low byte of the result when the destination is 8 bits wide. They use bit 15 and the full word when the destination is 16 bits wide. Code 8 always uses the 16-bit value.
- R9: The half swap (code 12) exchanges A and B. Its flags come from the new A, treated as 8 bits.
- R10: With `op_valid` low, or with code 0, no register changes.
- R11: Code 14 clears every status bit set in `wr_data[7:0]`. Code 15 sets every status bit set in `wr_data[7:0]`. The bit layout is C=0, Z=1, I=2, D=3, x=4, m=5, V=6, N=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Qualifies `op_sel` for this cycle |
| op_sel | input | 4 | Operation code |
| wr_data | input | 16 | Load value, or flag mask in the low byte |
| acc_full | output | 16 | Raw {B, A} |
| acc_out | output | 16 | Accumulator at its active width |
| x_out | output | 16 | Index register X |
| y_out | output | 16 | Index register Y |
| sp_out | output | 16 | Stack pointer |
| dp_out | output | 16 | Direct-page base |
| status_out | output | 8 | Status register |
| emu_out | output | 1 | Emulation flag |

## Verification
The bench targets four places where a flawed register file goes wrong. The first is an 8-bit accumulator write that also overwrites B, so a later 16-bit read returns a corrupted high half. The second is index high bytes that come back after x is cleared again. The third is flags taken at the wrong width, which shows up as N=1/Z=0 where the 8-bit result is zero. The fourth is direct-page and stack transfers that obey m and silently drop B. It also runs the exchange with both carry values in both modes. A design that swaps the wrong way, or fails to re-pin m, x and the stack page on return to emulation, shows a wrong mode flag, status byte or stack pointer.

// File: rtl/cpu_regfile_pkg.sv
package cpu_regfile_pkg;

    typedef enum logic [3:0] {
        OP_NOP         = 4'd0,
        OP_LOAD_ACC    = 4'd1,
        OP_LOAD_X      = 4'd2,
        OP_LOAD_Y      = 4'd3,
        OP_ACC_TO_X    = 4'd4,
        OP_ACC_TO_Y    = 4'd5,
        OP_X_TO_ACC    = 4'd6,
        OP_Y_TO_ACC    = 4'd7,
        OP_ACC_TO_DP   = 4'd8,
        OP_DP_TO_ACC   = 4'd9,
        OP_ACC_TO_SP   = 4'd10,
        OP_SP_TO_ACC   = 4'd11,
        OP_SWAP_HALVES = 4'd12,
        OP_SWAP_CE     = 4'd13,
        OP_CLR_FLAGS   = 4'd14,
        OP_SET_FLAGS   = 4'd15
    } op_e;

    typedef enum logic {
        MODE_EMU    = 1'b0,
        MODE_NATIVE = 1'b1
    } mode_e;

    localparam int ST_C = 0;
    localparam int ST_Z = 1;
    localparam int ST_I = 2;
    localparam int ST_D = 3;
    localparam int ST_X = 4;
    localparam int ST_M = 5;
    localparam int ST_V = 6;
    localparam int ST_N = 7;
    localparam int ST_W = 8;

    localparam logic [ST_W-1:0] STATUS_RESET = 8'h34;

endpackage

// File: rtl/regfile_mode_fsm.sv
module regfile_mode_fsm
    import cpu_regfile_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req,
    input  logic carry_in,
    output logic emu_now,
    output logic emu_next,
    output logic carry_out
);

    mode_e state_q;
    mode_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_EMU;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: EMU_TO_NATIVE on exchange with carry 0, NATIVE_TO_EMU on exchange with carry 1
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_EMU: begin
                if (swap_req && !carry_in) begin
                    state_d = MODE_NATIVE;
                end
            end
            MODE_NATIVE: begin
                if (swap_req && carry_in) begin
                    state_d = MODE_EMU;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        emu_now   = (state_q == MODE_EMU);
        emu_next  = (state_d == MODE_EMU);
        carry_out = (state_q == MODE_EMU);
    end

endmodule

// File: rtl/regfile_nz_gen.sv
module regfile_nz_gen #(
    parameter int BYTE_W = 8
) (
    input  logic [2*BYTE_W-1:0] value,
    input  logic                wide,
    output logic                neg,
    output logic                zero
);

    localparam int WORD_W = 2 * BYTE_W;

    always_comb begin
        if (wide) begin
            neg  = value[WORD_W-1];
            zero = (value == '0);
        end else begin
            neg  = value[BYTE_W-1];
            zero = (value[BYTE_W-1:0] == '0);
        end
    end

endmodule

// File: rtl/regfile_xfer_unit.sv
module regfile_xfer_unit
    import cpu_regfile_pkg::*;
#(
    parameter int                BYTE_W      = 8,
    parameter logic [BYTE_W-1:0] EMU_SP_PAGE = 'h01
) (
    input  logic                          op_valid,
    input  op_e                           op,
    input  logic [2*BYTE_W-1:0]           wr_data,
    input  logic [BYTE_W-1:0]             a_cur,
    input  logic [BYTE_W-1:0]             b_cur,
    input  logic [1:0][2*BYTE_W-1:0]      idx_cur,
    input  logic [2*BYTE_W-1:0]           sp_cur,
    input  logic [2*BYTE_W-1:0]           dp_cur,
    input  logic [ST_W-1:0]               p_cur,
    input  logic                          emu_next,
    input  logic                          carry_from_mode,
    output logic [BYTE_W-1:0]             a_nxt,
    output logic [BYTE_W-1:0]             b_nxt,
    output logic [1:0][2*BYTE_W-1:0]      idx_nxt,
    output logic [2*BYTE_W-1:0]           sp_nxt,
    output logic [2*BYTE_W-1:0]           dp_nxt,
    output logic [ST_W-1:0]               p_nxt
);

    localparam int WORD_W = 2 * BYTE_W;
    localparam int NUM_IDX = 2;

    logic                     acc_wide;
    logic                     idx_wide;
    logic [WORD_W-1:0]        acc_word;
    logic [BYTE_W-1:0]        r_a;
    logic [BYTE_W-1:0]        r_b;
    logic [1:0][WORD_W-1:0]   r_idx;
    logic [WORD_W-1:0]        r_sp;
    logic [WORD_W-1:0]        r_dp;
    logic [ST_W-1:0]          r_p;
    logic                     flag_upd;
    logic                     flag_wide;
    logic [WORD_W-1:0]        flag_val;
    logic                     flag_n;
    logic                     flag_z;

    assign acc_wide = !p_cur[ST_M];
    assign idx_wide = !p_cur[ST_X];
    assign acc_word = {b_cur, a_cur};

    // Stage 1: operation result before flags and mode constraints
    always_comb begin
        r_a       = a_cur;
        r_b       = b_cur;
        r_idx     = idx_cur;
        r_sp      = sp_cur;
        r_dp      = dp_cur;
        r_p       = p_cur;
        flag_upd  = 1'b0;
        flag_wide = 1'b0;
        flag_val  = '0;
        if (op_valid) begin
            unique case (op)
                OP_NOP: begin
                end
                OP_LOAD_ACC: begin
                    r_a = wr_data[BYTE_W-1:0];
                    if (acc_wide) r_b = wr_data[WORD_W-1:BYTE_W];
                    flag_upd  = 1'b1;
                    flag_wide = acc_wide;
                    flag_val  = wr_data;
                end
                OP_LOAD_X, OP_LOAD_Y: begin
                    flag_upd  = 1'b1;
                    flag_wide = idx_wide;
                    flag_val  = idx_wide ? wr_data
                                         : {{BYTE_W{1'b0}}, wr_data[BYTE_W-1:0]};
                    r_idx[(op == OP_LOAD_Y) ? 1 : 0] = flag_val;
                end
                OP_ACC_TO_X, OP_ACC_TO_Y: begin
                    flag_upd  = 1'b1;
                    flag_wide = idx_wide;
                    flag_val  = idx_wide ? acc_word : {{BYTE_W{1'b0}}, a_cur};
                    r_idx[(op == OP_ACC_TO_Y) ? 1 : 0] = flag_val;
                end
                OP_X_TO_ACC, OP_Y_TO_ACC: begin
                    flag_upd  = 1'b1;
                    flag_wide = acc_wide;
                    flag_val  = idx_cur[(op == OP_Y_TO_ACC) ? 1 : 0];
                    r_a = flag_val[BYTE_W-1:0];
                    if (acc_wide) r_b = flag_val[WORD_W-1:BYTE_W];
                end
                OP_ACC_TO_DP: begin
                    r_dp      = acc_word;
                    flag_upd  = 1'b1;
                    flag_wide = 1'b1;
                    flag_val  = acc_word;
                end
                OP_DP_TO_ACC: begin
                    {r_b, r_a} = dp_cur;
                    flag_upd   = 1'b1;
                    flag_wide  = 1'b1;
                    flag_val   = dp_cur;
                end
                OP_ACC_TO_SP: begin
                    r_sp = acc_word;
                end
                OP_SP_TO_ACC: begin
                    {r_b, r_a} = sp_cur;
                    flag_upd   = 1'b1;
                    flag_wide  = 1'b1;
                    flag_val   = sp_cur;
                end
                OP_SWAP_HALVES: begin
                    r_a       = b_cur;
                    r_b       = a_cur;
                    flag_upd  = 1'b1;
                    flag_wide = 1'b0;
                    flag_val  = {{BYTE_W{1'b0}}, b_cur};
                end
                OP_SWAP_CE: begin
                    r_p[ST_C] = carry_from_mode;
                end
                OP_CLR_FLAGS: begin
                    r_p = p_cur & ~wr_data[ST_W-1:0];
                end
                OP_SET_FLAGS: begin
                    r_p = p_cur | wr_data[ST_W-1:0];
                end
            endcase
        end
    end

    regfile_nz_gen #(
        .BYTE_W (BYTE_W)
    ) u_nz (
        .value (flag_val),
        .wide  (flag_wide),
        .neg   (flag_n),
        .zero  (flag_z)
    );

    // Stage 2: flag update and mode constraints
    always_comb begin
        a_nxt   = r_a;
        b_nxt   = r_b;
        dp_nxt  = r_dp;
        sp_nxt  = r_sp;
        p_nxt   = r_p;
        if (flag_upd) begin
            p_nxt[ST_N] = flag_n;
            p_nxt[ST_Z] = flag_z;
        end
        if (emu_next) begin
            p_nxt[ST_M]                = 1'b1;
            p_nxt[ST_X]                = 1'b1;
            sp_nxt[WORD_W-1:BYTE_W]    = EMU_SP_PAGE;
        end
    end

    for (genvar k = 0; k < NUM_IDX; k++) begin : g_idx_clip
        always_comb begin
            idx_nxt[k] = r_idx[k];
            if (p_nxt[ST_X]) begin
                idx_nxt[k][WORD_W-1:BYTE_W] = '0;
            end
        end
    end

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import cpu_regfile_pkg::*;
#(
    parameter int                BYTE_W      = 8,
    parameter logic [BYTE_W-1:0] EMU_SP_PAGE = 'h01,
    parameter logic [BYTE_W-1:0] SP_RESET_LO = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [3:0]            op_sel,
    input  logic [2*BYTE_W-1:0]   wr_data,
    output logic [2*BYTE_W-1:0]   acc_full,
    output logic [2*BYTE_W-1:0]   acc_out,
    output logic [2*BYTE_W-1:0]   x_out,
    output logic [2*BYTE_W-1:0]   y_out,
    output logic [2*BYTE_W-1:0]   sp_out,
    output logic [2*BYTE_W-1:0]   dp_out,
    output logic [7:0]            status_out,
    output logic                  emu_out
);

    localparam int WORD_W  = 2 * BYTE_W;
    localparam int NUM_IDX = 2;

    op_e                     op;
    logic [BYTE_W-1:0]       a_q, a_d;
    logic [BYTE_W-1:0]       b_q, b_d;
    logic [1:0][WORD_W-1:0]  idx_q, idx_d;
    logic [WORD_W-1:0]       sp_q, sp_d;
    logic [WORD_W-1:0]       dp_q, dp_d;
    logic [ST_W-1:0]         p_q, p_d;
    logic                    emu_now;
    logic                    emu_next;
    logic                    carry_from_mode;

    assign op = op_e'(op_sel);

    regfile_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap_req  (op_valid && (op == OP_SWAP_CE)),
        .carry_in  (p_q[ST_C]),
        .emu_now   (emu_now),
        .emu_next  (emu_next),
        .carry_out (carry_from_mode)
    );

    regfile_xfer_unit #(
        .BYTE_W      (BYTE_W),
        .EMU_SP_PAGE (EMU_SP_PAGE)
    ) u_xfer (
        .op_valid        (op_valid),
        .op              (op),
        .wr_data         (wr_data),
        .a_cur           (a_q),
        .b_cur           (b_q),
        .idx_cur         (idx_q),
        .sp_cur          (sp_q),
        .dp_cur          (dp_q),
        .p_cur           (p_q),
        .emu_next        (emu_next),
        .carry_from_mode (carry_from_mode),
        .a_nxt           (a_d),
        .b_nxt           (b_d),
        .idx_nxt         (idx_d),
        .sp_nxt          (sp_d),
        .dp_nxt          (dp_d),
        .p_nxt           (p_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            sp_q <= {EMU_SP_PAGE, SP_RESET_LO};
            dp_q <= '0;
            p_q  <= STATUS_RESET;
        end else begin
            a_q  <= a_d;
            b_q  <= b_d;
            sp_q <= sp_d;
            dp_q <= dp_d;
            p_q  <= p_d;
        end
    end

    for (genvar k = 0; k < NUM_IDX; k++) begin : g_idx_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                idx_q[k] <= '0;
            end else begin
                idx_q[k] <= idx_d[k];
            end
        end
    end

    always_comb begin
        acc_full   = {b_q, a_q};
        acc_out    = p_q[ST_M] ? {{BYTE_W{1'b0}}, a_q} : {b_q, a_q};
        x_out      = idx_q[0];
        y_out      = idx_q[1];
        sp_out     = sp_q;
        dp_out     = dp_q;
        status_out = p_q;
        emu_out    = emu_now;
    end

endmodule

// File: rtl/cpu_regfile_chk.sv
module cpu_regfile_chk #(
    parameter int                BYTE_W      = 8,
    parameter logic [BYTE_W-1:0] EMU_SP_PAGE = 'h01
) (
    input logic                clk,
    input logic                rst_n,
    input logic                op_valid,
    input logic [3:0]          op_sel,
    input logic [2*BYTE_W-1:0] acc_full,
    input logic [2*BYTE_W-1:0] acc_out,
    input logic [2*BYTE_W-1:0] x_out,
    input logic [2*BYTE_W-1:0] y_out,
    input logic [2*BYTE_W-1:0] sp_out,
    input logic [2*BYTE_W-1:0] dp_out,
    input logic [7:0]          status_out,
    input logic                emu_out
);

    localparam int WORD_W = 2 * BYTE_W;

    assert_b_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd1 && status_out[5])
        |=> (acc_full[WORD_W-1:BYTE_W] == $past(acc_full[WORD_W-1:BYTE_W])));

    assert_idx_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        status_out[4] |-> (x_out[WORD_W-1:BYTE_W] == '0 && y_out[WORD_W-1:BYTE_W] == '0));

    assert_dp_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd8) |=> (dp_out == $past(acc_full)));

    assert_ce_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd13)
        |=> (emu_out == $past(status_out[0]) && status_out[0] == $past(emu_out)));

    assert_emu_pinned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        emu_out |-> (status_out[5] && status_out[4] && sp_out[WORD_W-1:BYTE_W] == EMU_SP_PAGE));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_out) && $stable(acc_full) && $stable(status_out)
                      && $stable(emu_out) && $stable(x_out) && $stable(y_out)
                      && $stable(sp_out) && $stable(dp_out)));

endmodule

bind cpu_regfile cpu_regfile_chk #(
    .BYTE_W      (BYTE_W),
    .EMU_SP_PAGE (EMU_SP_PAGE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_sel     (op_sel),
    .acc_full   (acc_full),
    .acc_out    (acc_out),
    .x_out      (x_out),
    .y_out      (y_out),
    .sp_out     (sp_out),
    .dp_out     (dp_out),
    .status_out (status_out),
    .emu_out    (emu_out)
);

// File: tb/tb_cpu_regfile.sv
`timescale 1ns/1ps
module tb_cpu_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] acc_full, acc_out, x_out, y_out, sp_out, dp_out;
    logic [7:0]  status_out;
    logic        emu_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cpu_regfile dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .wr_data(wr_data), .acc_full(acc_full), .acc_out(acc_out),
        .x_out(x_out), .y_out(y_out), .sp_out(sp_out), .dp_out(dp_out),
        .status_out(status_out), .emu_out(emu_out)
    );

    typedef struct packed {
        logic        vld;
        logic [3:0]  op;
        logic [15:0] data;
        logic [15:0] e_acc;
        logic [15:0] e_x;
        logic [15:0] e_y;
        logic [15:0] e_sp;
        logic [15:0] e_dp;
        logic [7:0]  e_p;
        logic        e_e;
        logic [3:0]  req;
    } vec_t;

    // vld op data | acc x y sp dp status emu | requirement
    localparam vec_t TBL [33] = '{
        '{1'b1, 4'd1,  16'h1280, 16'h0080, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 8'hB4, 1'b1, 4'd2},  // R2 8-bit load
        '{1'b1, 4'd14, 16'h0030, 16'h0080, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 8'hB4, 1'b1, 4'd7},  // R7 widths pinned
        '{1'b1, 4'd10, 16'h0000, 16'h0080, 16'h0000, 16'h0000, 16'h0180, 16'h0000, 8'hB4, 1'b1, 4'd7},  // R7 stack page
        '{1'b1, 4'd15, 16'h0001, 16'h0080, 16'h0000, 16'h0000, 16'h0180, 16'h0000, 8'hB5, 1'b1, 4'd11}, // R11 set carry
        '{1'b1, 4'd13, 16'h0000, 16'h0080, 16'h0000, 16'h0000, 16'h0180, 16'h0000, 8'hB5, 1'b1, 4'd6},  // R6 stay emu
        '{1'b1, 4'd14, 16'h0001, 16'h0080, 16'h0000, 16'h0000, 16'h0180, 16'h0000, 8'hB4, 1'b1, 4'd11}, // R11 clear carry
        '{1'b1, 4'd13, 16'h0000, 16'h0080, 16'h0000, 16'h0000, 16'h0180, 16'h0000, 8'hB5, 1'b0, 4'd6},  // R6 to native
        '{1'b1, 4'd1,  16'hABCD, 16'h00CD, 16'h0000, 16'h0000, 16'h0180, 16'h0000, 8'hB5, 1'b0, 4'd8},  // R8
        '{1'b1, 4'd12, 16'h0000, 16'hCD00, 16'h0000, 16'h0000, 16'h0180, 16'h0000, 8'h37, 1'b0, 4'd9},  // R9 swap
        '{1'b1, 4'd1,  16'h1234, 16'hCD34, 16'h0000, 16'h0000, 16'h0180, 16'h0000, 8'h35, 1'b0, 4'd2},  // R2 B kept
        '{1'b1, 4'd14, 16'h0020, 16'hCD34, 16'h0000, 16'h0000, 16'h0180, 16'h0000, 8'h15, 1'b0, 4'd4},  // R4 clear m
        '{1'b1, 4'd1,  16'h8001, 16'h8001, 16'h0000, 16'h0000, 16'h0180, 16'h0000, 8'h95, 1'b0, 4'd8},  // R8 16-bit
        '{1'b1, 4'd4,  16'h0000, 16'h8001, 16'h0001, 16'h0000, 16'h0180, 16'h0000, 8'h15, 1'b0, 4'd3},  // R3 narrow X
        '{1'b1, 4'd14, 16'h0010, 16'h8001, 16'h0001, 16'h0000, 16'h0180, 16'h0000, 8'h05, 1'b0, 4'd4},  // R4 clear x
        '{1'b1, 4'd5,  16'h0000, 16'h8001, 16'h0001, 16'h8001, 16'h0180, 16'h0000, 8'h85, 1'b0, 4'd8},  // R8
        '{1'b1, 4'd2,  16'hFF00, 16'h8001, 16'hFF00, 16'h8001, 16'h0180, 16'h0000, 8'h85, 1'b0, 4'd8},  // R8
        '{1'b1, 4'd15, 16'h0020, 16'h8001, 16'hFF00, 16'h8001, 16'h0180, 16'h0000, 8'hA5, 1'b0, 4'd4},  // R4 set m only
        '{1'b1, 4'd6,  16'h0000, 16'h8000, 16'hFF00, 16'h8001, 16'h0180, 16'h0000, 8'h27, 1'b0, 4'd2},  // R2 narrow to A
        '{1'b1, 4'd8,  16'h0000, 16'h8000, 16'hFF00, 16'h8001, 16'h0180, 16'h8000, 8'hA5, 1'b0, 4'd5},  // R5
        '{1'b1, 4'd1,  16'h0055, 16'h8055, 16'hFF00, 16'h8001, 16'h0180, 16'h8000, 8'h25, 1'b0, 4'd2},  // R2
        '{1'b1, 4'd9,  16'h0000, 16'h8000, 16'hFF00, 16'h8001, 16'h0180, 16'h8000, 8'hA5, 1'b0, 4'd5},  // R5
        '{1'b1, 4'd11, 16'h0000, 16'h0180, 16'hFF00, 16'h8001, 16'h0180, 16'h8000, 8'h25, 1'b0, 4'd5},  // R5
        '{1'b1, 4'd14, 16'h0020, 16'h0180, 16'hFF00, 16'h8001, 16'h0180, 16'h8000, 8'h05, 1'b0, 4'd11}, // R11
        '{1'b1, 4'd1,  16'h2468, 16'h2468, 16'hFF00, 16'h8001, 16'h0180, 16'h8000, 8'h05, 1'b0, 4'd2},  // R2
        '{1'b1, 4'd10, 16'h0000, 16'h2468, 16'hFF00, 16'h8001, 16'h2468, 16'h8000, 8'h05, 1'b0, 4'd5},  // R5
        '{1'b1, 4'd15, 16'h0010, 16'h2468, 16'h0000, 16'h0001, 16'h2468, 16'h8000, 8'h15, 1'b0, 4'd3},  // R3 clip
        '{1'b1, 4'd14, 16'h0010, 16'h2468, 16'h0000, 16'h0001, 16'h2468, 16'h8000, 8'h05, 1'b0, 4'd3},  // R3 stays
        '{1'b1, 4'd3,  16'h0000, 16'h2468, 16'h0000, 16'h0000, 16'h2468, 16'h8000, 8'h07, 1'b0, 4'd8},  // R8 zero
        '{1'b1, 4'd2,  16'hC3A5, 16'h2468, 16'hC3A5, 16'h0000, 16'h2468, 16'h8000, 8'h85, 1'b0, 4'd8},  // R8
        '{1'b1, 4'd13, 16'h0000, 16'h2468, 16'h00A5, 16'h0000, 16'h0168, 16'h8000, 8'hB4, 1'b1, 4'd7},  // R7 back to emu
        '{1'b1, 4'd1,  16'h0000, 16'h2400, 16'h00A5, 16'h0000, 16'h0168, 16'h8000, 8'h36, 1'b1, 4'd2},  // R2
        '{1'b0, 4'd1,  16'hFFFF, 16'h2400, 16'h00A5, 16'h0000, 16'h0168, 16'h8000, 8'h36, 1'b1, 4'd10}, // R10 idle
        '{1'b1, 4'd0,  16'hFFFF, 16'h2400, 16'h00A5, 16'h0000, 16'h0168, 16'h8000, 8'h36, 1'b1, 4'd10}  // R10 nop
    };

    task automatic apply(input logic vld, input logic [3:0] op, input logic [15:0] data);
        @(negedge clk);
        op_valid = vld;
        op_sel   = op;
        wr_data  = data;
        @(negedge clk);
        op_valid = 1'b0;
        op_sel   = 4'd0;
    endtask

    task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [15:0] ea, input logic [15:0] ex,
                           input logic [15:0] ey, input logic [15:0] es, input logic [15:0] ed,
                           input logic [7:0] ep, input logic ee);
        checks++;
        if (acc_full !== ea || x_out !== ex || y_out !== ey || sp_out !== es ||
            dp_out !== ed || status_out !== ep || emu_out !== ee) begin
            fails++;
            $display("FAIL %s actual acc=%h x=%h y=%h sp=%h dp=%h p=%h e=%b expected acc=%h x=%h y=%h sp=%h dp=%h p=%h e=%b",
                     tag, acc_full, x_out, y_out, sp_out, dp_out, status_out, emu_out,
                     ea, ex, ey, es, ed, ep, ee);
        end
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        checks++;
        fails++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_all("R1 reset", 16'h0000, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 8'h34, 1'b1);

        for (int i = 0; i < 33; i++) begin
            apply(TBL[i].vld, TBL[i].op, TBL[i].data);
            chk_all($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].e_acc, TBL[i].e_x,
                    TBL[i].e_y, TBL[i].e_sp, TBL[i].e_dp, TBL[i].e_p, TBL[i].e_e);
        end

        // R2 view in emulation hides B
        chk16("R2 acc_out narrow", acc_out, 16'h0000);

        // R1 reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_all("R1 mid-run reset", 16'h0000, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 8'h34, 1'b1);
        rst_n = 1'b1;

        // R6 clear carry then exchange
        apply(1'b1, 4'd14, 16'h0001);
        apply(1'b1, 4'd13, 16'h0000);
        chk_all("R6 clear-then-exchange", 16'h0000, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 8'h35, 1'b0);

        // R4 both widths cleared in native
        apply(1'b1, 4'd14, 16'h0030);
        chk_all("R4 both wide", 16'h0000, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 8'h05, 1'b0);

        // R8 16-bit load, full view
        apply(1'b1, 4'd1, 16'hFFFF);
        chk16("R8 wide acc_out", acc_out, 16'hFFFF);
        chk16("R8 wide flags", {8'h00, status_out}, 16'h0085);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule